// File: doc/BRIEF.md
# SATA link power state controller

This block decides the power state of the link behind one Serial ATA host port. The link is in one of three states: on, Partial or Slumber. Software enters a low-power state by setting one of two request bits. While a bit is set, the block keeps asking the link layer to transmit the matching power-request primitive. It moves to the requested state only when the device answers with an acknowledge. A refusal from the device changes nothing, and the request keeps going out.

The device may also ask for a low-power state. The block answers each such request on the following cycle. It sends an acknowledge and enters the state if software has enabled acceptance for that state. Otherwise it sends a refusal. Two events bring the link back to the on state: a wake command from software, which also raises a one-cycle COMWAKE transmit request, and an out-of-band wake from the device. The current state is reported three ways: an encoded 4-bit field, a pair of mode bits, and a sticky change flag. The change flag drives an interrupt output that software can mask.

Top module: `lpm_ctrl`

## Requirements
- R1: When `rst_n` is low, the block is held in the on state: `ipm_status` = 4'b0001, `mode_bits` = 2'b00, and every transmit request, `mode_chg`, `wake_rx` and `irq` are 0.
- R2: In the on state, `tx_pmreq_s` follows `sw_req[1]` combinationally. `tx_pmreq_p` follows `sw_req[0]` only while `sw_req[1]` is 0, so Slumber wins when both bits are set.
- R3: In the on state with a request bit set, `rx_pmack` moves the block to the requested state at the next clock edge. `rx_pmnak` leaves the state unchanged and the request keeps being sent.
- R4: In the on state with `sw_req` = 0, a received `rx_pmreq_s` (or else `rx_pmreq_p`) gives a one-cycle `tx_pmack` after the edge if `ack_en[1]` (or `ack_en[0]`) is 1, and the block enters Slumber (Partial) at that edge. Otherwise it gives a one-cycle `tx_pmnak`. A wake event in the same cycle drops the device request. Bits 3:2 of `ack_en` have no effect.
- R5: `ipm_status` reads 4'b0001 when on, 4'b0010 in Partial and 4'b0110 in Slumber. `mode_bits[1]` is 1 in Slumber and `mode_bits[0]` is 1 in Partial.
- R6: In Partial or Slumber, `sw_req` and the received power primitives have no effect: no transmit request is raised and the state does not change.
- R7: `wake_cmd` gives a one-cycle `tx_comwake` after the next edge and returns a low-power state to on at that edge.
- R8: `rx_oob_wake` returns the block to on at the next edge and sets the sticky `wake_rx`. A write of 1 to `clr_wake` clears it, and a set in the same cycle wins over the clear.
- R9: At the edge after `mode_bits` changes, the sticky `mode_chg` is set. A write of 1 to `clr_chg` clears it, and a new change in the same cycle wins over the clear.
- R10: `irq` is 1 exactly when `mode_chg` and `irq_en` are both 1. This applies with the default combinational interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_req | input | 2 | Software request bits: [1] Slumber, [0] Partial |
| ack_en | input | IPM_W | Device-request accept enables: [1] Slumber, [0] Partial |
| wake_cmd | input | 1 | Software wake command pulse |
| irq_en | input | 1 | Interrupt enable for the mode-change flag |
| clr_chg | input | 1 | Write-1 clear of `mode_chg` |
| clr_wake | input | 1 | Write-1 clear of `wake_rx` |
| rx_pmreq_p | input | 1 | Partial request received from the device |
| rx_pmreq_s | input | 1 | Slumber request received from the device |
| rx_pmack | input | 1 | Acknowledge received |
| rx_pmnak | input | 1 | Refusal received |
| rx_oob_wake | input | 1 | Out-of-band wake detected from the device |
| tx_pmreq_p | output | 1 | Send Partial request primitive |
| tx_pmreq_s | output | 1 | Send Slumber request primitive |
| tx_pmack | output | 1 | Send acknowledge primitive |
| tx_pmnak | output | 1 | Send refusal primitive |
| tx_comwake | output | 1 | Transmit COMWAKE |
| ipm_status | output | IPM_W | Encoded power state |
| mode_bits | output | 2 | [1] in Slumber, [0] in Partial |
| mode_chg | output | 1 | Sticky mode-change flag |
| wake_rx | output | 1 | Sticky received-wake flag |
| irq | output | 1 | Masked mode-change interrupt |

## Verification
The bench drives several corner cases, each of which catches a specific design fault.
- Both request bits set at once. A design with the wrong priority would send both request primitives, or enter Partial.
- Repeated refusals. A design that drops the request after a refusal would fall silent.
- A clear written in the same cycle as a new mode change or wake. If the clear won, the event would be lost.
- Device requests with only one enable bit set, and requests that arrive while already in a low-power state. A design that decodes the wrong enable bit would answer wrongly. One that does not ignore requests in a low-power state would jump between states.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
   typedef enum logic [1:0] {
      LPS_ON   = 2'd0,
      LPS_PART = 2'd1,
      LPS_SLUM = 2'd2
   } lps_e;
endpackage

// File: rtl/lpm_req_sel.sv
// Two-way request selector: the upper request wins, both gated by enable.
module lpm_req_sel (
   input  logic [1:0] req_bits,
   input  logic       enable,
   output logic       pick_lo,
   output logic       pick_hi
);
   assign pick_hi = enable & req_bits[1];
   assign pick_lo = enable & req_bits[0] & ~req_bits[1];
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
   import lpm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       host_p,
   input  logic       host_s,
   input  logic       dev_p,
   input  logic       dev_s,
   input  logic [1:0] acc_en,
   input  logic       rx_pmack,
   input  logic       wake_cmd,
   input  logic       rx_oob_wake,
   output lps_e       state,
   output logic       tx_pmack,
   output logic       tx_pmnak,
   output logic       tx_comwake
);
   lps_e nxt;
   logic ack_d, nak_d;
   logic wake_any;

   assign wake_any = wake_cmd | rx_oob_wake;

   always_comb begin
      nxt   = state;
      ack_d = 1'b0;
      nak_d = 1'b0;
      case (state)
         LPS_ON: begin
            if (!wake_any) begin
               if (host_s || host_p) begin
                  if (rx_pmack) nxt = host_s ? LPS_SLUM : LPS_PART;
               end else if (dev_s) begin
                  if (acc_en[1]) begin
                     nxt   = LPS_SLUM;
                     ack_d = 1'b1;
                  end else begin
                     nak_d = 1'b1;
                  end
               end else if (dev_p) begin
                  if (acc_en[0]) begin
                     nxt   = LPS_PART;
                     ack_d = 1'b1;
                  end else begin
                     nak_d = 1'b1;
                  end
               end
            end
         end
         default: begin
            if (wake_any) nxt = LPS_ON;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= LPS_ON;
         tx_pmack   <= 1'b0;
         tx_pmnak   <= 1'b0;
         tx_comwake <= 1'b0;
      end else begin
         state      <= nxt;
         tx_pmack   <= ack_d;
         tx_pmnak   <= nak_d;
         tx_comwake <= wake_cmd;
      end
   end
endmodule

// File: rtl/lpm_flags.sv
module lpm_flags #(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_bits,
   input  logic       rx_oob_wake,
   input  logic       clr_chg,
   input  logic       clr_wake,
   input  logic       irq_en,
   output logic       mode_chg,
   output logic       wake_rx,
   output logic       irq
);
   logic [1:0] mode_prev;
   logic       chg_evt;

   assign chg_evt = |(mode_bits ^ mode_prev);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_prev <= 2'b00;
         mode_chg  <= 1'b0;
         wake_rx   <= 1'b0;
      end else begin
         mode_prev <= mode_bits;
         mode_chg  <= chg_evt | (mode_chg & ~clr_chg);
         wake_rx   <= rx_oob_wake | (wake_rx & ~clr_wake);
      end
   end

   generate
      if (IRQ_REG) begin : g_irq_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= mode_chg & irq_en;
         end
      end else begin : g_irq_comb
         assign irq = mode_chg & irq_en;
      end
   endgenerate
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
   import lpm_pkg::*;
#(
   parameter int               IPM_W       = 4,
   parameter logic [IPM_W-1:0] STS_ACTIVE  = 4'b0001,
   parameter logic [IPM_W-1:0] STS_PARTIAL = 4'b0010,
   parameter logic [IPM_W-1:0] STS_SLUMBER = 4'b0110,
   parameter bit               IRQ_REG     = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       sw_req,
   input  logic [IPM_W-1:0] ack_en,
   input  logic             wake_cmd,
   input  logic             irq_en,
   input  logic             clr_chg,
   input  logic             clr_wake,
   input  logic             rx_pmreq_p,
   input  logic             rx_pmreq_s,
   input  logic             rx_pmack,
   input  logic             rx_pmnak,
   input  logic             rx_oob_wake,
   output logic             tx_pmreq_p,
   output logic             tx_pmreq_s,
   output logic             tx_pmack,
   output logic             tx_pmnak,
   output logic             tx_comwake,
   output logic [IPM_W-1:0] ipm_status,
   output logic [1:0]       mode_bits,
   output logic             mode_chg,
   output logic             wake_rx,
   output logic             irq
);
   localparam int ACC_BITS = 2;

   generate
      if (IPM_W < ACC_BITS) begin : g_bad_width
         $error("lpm_ctrl: IPM_W must be at least 2");
      end
      if (STS_ACTIVE == STS_PARTIAL || STS_ACTIVE == STS_SLUMBER
          || STS_PARTIAL == STS_SLUMBER) begin : g_bad_codes
         $error("lpm_ctrl: status codes must be distinct");
      end
      if (IPM_W > ACC_BITS) begin : g_acc_hi
         logic unused_acc_hi;
         assign unused_acc_hi = ^ack_en[IPM_W-1:ACC_BITS];
      end
   endgenerate

   lps_e state;
   logic in_on, dev_en;
   logic host_p, host_s, dev_p, dev_s;
   logic unused_nak;

   // A refusal needs no action: the request simply stays asserted.
   assign unused_nak = rx_pmnak;
   assign in_on  = (state == LPS_ON);
   assign dev_en = in_on & ~(|sw_req);

   lpm_req_sel u_host_sel (
      .req_bits (sw_req),
      .enable   (in_on),
      .pick_lo  (host_p),
      .pick_hi  (host_s)
   );

   lpm_req_sel u_dev_sel (
      .req_bits ({rx_pmreq_s, rx_pmreq_p}),
      .enable   (dev_en),
      .pick_lo  (dev_p),
      .pick_hi  (dev_s)
   );

   lpm_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .host_p      (host_p),
      .host_s      (host_s),
      .dev_p       (dev_p),
      .dev_s       (dev_s),
      .acc_en      (ack_en[ACC_BITS-1:0]),
      .rx_pmack    (rx_pmack),
      .wake_cmd    (wake_cmd),
      .rx_oob_wake (rx_oob_wake),
      .state       (state),
      .tx_pmack    (tx_pmack),
      .tx_pmnak    (tx_pmnak),
      .tx_comwake  (tx_comwake)
   );

   assign tx_pmreq_p = host_p;
   assign tx_pmreq_s = host_s;

   always_comb begin
      case (state)
         LPS_PART: ipm_status = STS_PARTIAL;
         LPS_SLUM: ipm_status = STS_SLUMBER;
         default:  ipm_status = STS_ACTIVE;
      endcase
   end

   assign mode_bits = {state == LPS_SLUM, state == LPS_PART};

   lpm_flags #(.IRQ_REG(IRQ_REG)) u_flags (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_bits   (mode_bits),
      .rx_oob_wake (rx_oob_wake),
      .clr_chg     (clr_chg),
      .clr_wake    (clr_wake),
      .irq_en      (irq_en),
      .mode_chg    (mode_chg),
      .wake_rx     (wake_rx),
      .irq         (irq)
   );
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
   parameter int               IPM_W       = 4,
   parameter logic [IPM_W-1:0] STS_ACTIVE  = 4'b0001,
   parameter logic [IPM_W-1:0] STS_PARTIAL = 4'b0010,
   parameter logic [IPM_W-1:0] STS_SLUMBER = 4'b0110,
   parameter bit               IRQ_REG     = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       sw_req,
   input logic             wake_cmd,
   input logic             irq_en,
   input logic             clr_chg,
   input logic             rx_pmreq_p,
   input logic             rx_pmreq_s,
   input logic             rx_pmack,
   input logic             rx_oob_wake,
   input logic             tx_pmreq_p,
   input logic             tx_pmreq_s,
   input logic             tx_pmack,
   input logic             tx_pmnak,
   input logic             tx_comwake,
   input logic [IPM_W-1:0] ipm_status,
   input logic             mode_chg,
   input logic             wake_rx,
   input logic             irq
);
   logic on_q;
   assign on_q = (ipm_status == STS_ACTIVE);

   AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_pmreq_p && tx_pmreq_s));                                          // R2
   AST_ACK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (on_q && sw_req != 2'b00 && rx_pmack && !wake_cmd && !rx_oob_wake)
      |=> !on_q);                                                           // R3
   AST_NAK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (on_q && sw_req != 2'b00 && !rx_pmack) |=> on_q);                     // R3
   AST_DEV_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
      (on_q && sw_req == 2'b00 && (rx_pmreq_p || rx_pmreq_s)
       && !wake_cmd && !rx_oob_wake) |=> (tx_pmack != tx_pmnak));            // R4
   AST_STS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      on_q || ipm_status == STS_PARTIAL || ipm_status == STS_SLUMBER);      // R5
   AST_LP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !on_q |-> !(tx_pmreq_p || tx_pmreq_s));                               // R6
   AST_WAKE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      wake_cmd |=> (tx_comwake && on_q));                                   // R7
   AST_OOB_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_oob_wake |=> (wake_rx && on_q));                                   // R8
   AST_CHG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_chg && !clr_chg) |=> mode_chg);                                 // R9

   generate
      if (IRQ_REG) begin : g_chk_reg
         AST_IRQ_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_chg && irq_en) |=> irq);                                  // R10
      end else begin : g_chk_comb
         AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
            irq |-> (irq_en && mode_chg));                                  // R10
      end
   endgenerate
endmodule

bind lpm_ctrl lpm_ctrl_chk #(
   .IPM_W       (IPM_W),
   .STS_ACTIVE  (STS_ACTIVE),
   .STS_PARTIAL (STS_PARTIAL),
   .STS_SLUMBER (STS_SLUMBER),
   .IRQ_REG     (IRQ_REG)
) u_chk (.*);

// File: tb/sim_lpm_ctrl.sv
`timescale 1ns/1ps
module sim_lpm_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] sw_req = '0;
   logic [3:0] ack_en = '0;
   logic       wake_cmd = 0, irq_en = 0, clr_chg = 0, clr_wake = 0;
   logic       rx_pmreq_p = 0, rx_pmreq_s = 0, rx_pmack = 0, rx_pmnak = 0, rx_oob_wake = 0;
   logic       tx_pmreq_p, tx_pmreq_s, tx_pmack, tx_pmnak, tx_comwake;
   logic [3:0] ipm_status;
   logic [1:0] mode_bits;
   logic       mode_chg, wake_rx, irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #2 clk = ~clk;

   lpm_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .ack_en(ack_en),
      .wake_cmd(wake_cmd), .irq_en(irq_en), .clr_chg(clr_chg), .clr_wake(clr_wake),
      .rx_pmreq_p(rx_pmreq_p), .rx_pmreq_s(rx_pmreq_s), .rx_pmack(rx_pmack),
      .rx_pmnak(rx_pmnak), .rx_oob_wake(rx_oob_wake),
      .tx_pmreq_p(tx_pmreq_p), .tx_pmreq_s(tx_pmreq_s), .tx_pmack(tx_pmack),
      .tx_pmnak(tx_pmnak), .tx_comwake(tx_comwake), .ipm_status(ipm_status),
      .mode_bits(mode_bits), .mode_chg(mode_chg), .wake_rx(wake_rx), .irq(irq)
   );

   typedef struct packed {
      logic [3:0] rq;
      logic [1:0] sw;
      logic [1:0] ae;
      logic wk, rp, rs, ra, rn, ob, ie, cc, cw;
      logic ep, es, ek, en, ec;
      logic [3:0] sts;
      logic echg, ewk, eirq;
   } vec_t;

   localparam int NV = 26;
   //  rq  sw ae  wk rp rs ra rn ob ie cc cw | ep es ek en ec sts chg wk irq
   localparam vec_t VEC [NV] = '{
      '{2,  1, 0,  0, 0, 0, 0, 0, 0, 0, 0, 0,  1, 0, 0, 0, 0, 1, 0, 0, 0},  // R2 Partial request
      '{3,  1, 0,  0, 0, 0, 0, 1, 0, 0, 0, 0,  1, 0, 0, 0, 0, 1, 0, 0, 0},  // R3 refusal
      '{3,  1, 0,  0, 0, 0, 1, 0, 0, 0, 0, 0,  0, 0, 0, 0, 0, 2, 0, 0, 0},  // R3 ack enters
      '{6,  1, 0,  0, 0, 0, 0, 0, 0, 1, 0, 0,  0, 0, 0, 0, 0, 2, 1, 0, 1},  // R6 request ignored
      '{7,  0, 0,  1, 0, 0, 0, 0, 0, 1, 0, 0,  0, 0, 0, 0, 1, 1, 1, 0, 1},  // R7 wake command
      '{9,  0, 0,  0, 0, 0, 0, 0, 0, 1, 1, 0,  0, 0, 0, 0, 0, 1, 1, 0, 1},  // R9 event beats clear
      '{10, 0, 0,  0, 0, 0, 0, 0, 0, 0, 1, 0,  0, 0, 0, 0, 0, 1, 0, 0, 0},  // R10 clear, masked
      '{2,  3, 0,  0, 0, 0, 0, 0, 0, 0, 0, 0,  0, 1, 0, 0, 0, 1, 0, 0, 0},  // R2 Slumber priority
      '{3,  3, 0,  0, 0, 0, 1, 0, 0, 0, 0, 0,  0, 0, 0, 0, 0, 6, 0, 0, 0},  // R3 enter Slumber
      '{10, 0, 0,  0, 0, 0, 0, 0, 0, 0, 0, 0,  0, 0, 0, 0, 0, 6, 1, 0, 0},  // R10 masked irq
      '{8,  0, 0,  0, 0, 0, 0, 0, 1, 0, 0, 0,  0, 0, 0, 0, 0, 1, 1, 1, 0},  // R8 oob wake
      '{9,  0, 0,  0, 0, 0, 0, 0, 0, 0, 1, 1,  0, 0, 0, 0, 0, 1, 1, 0, 0},  // R9 chg event vs clear
      '{9,  0, 0,  0, 0, 0, 0, 0, 0, 0, 1, 0,  0, 0, 0, 0, 0, 1, 0, 0, 0},  // R9 cleared
      '{4,  0, 1,  0, 0, 1, 0, 0, 0, 0, 0, 0,  0, 0, 0, 1, 0, 1, 0, 0, 0},  // R4 Slumber refused
      '{4,  0, 1,  0, 1, 0, 0, 0, 0, 0, 0, 0,  0, 0, 1, 0, 0, 2, 0, 0, 0},  // R4 Partial accepted
      '{6,  0, 3,  0, 0, 1, 0, 0, 0, 0, 0, 0,  0, 0, 0, 0, 0, 2, 1, 0, 0},  // R6 device req ignored
      '{8,  0, 0,  0, 0, 0, 0, 0, 1, 0, 0, 1,  0, 0, 0, 0, 0, 1, 1, 1, 0},  // R8 set beats clear
      '{9,  0, 0,  0, 0, 0, 0, 0, 0, 0, 1, 1,  0, 0, 0, 0, 0, 1, 1, 0, 0},  // R9
      '{9,  0, 0,  0, 0, 0, 0, 0, 0, 0, 1, 0,  0, 0, 0, 0, 0, 1, 0, 0, 0},  // R9
      '{4,  0, 2,  0, 0, 1, 0, 0, 0, 0, 0, 0,  0, 0, 1, 0, 0, 6, 0, 0, 0},  // R4 Slumber accepted
      '{6,  0, 3,  0, 1, 0, 0, 0, 0, 0, 0, 0,  0, 0, 0, 0, 0, 6, 1, 0, 0},  // R6
      '{7,  0, 0,  1, 0, 0, 0, 0, 0, 0, 0, 0,  0, 0, 0, 0, 1, 1, 1, 0, 0},  // R7 wake from Slumber
      '{9,  0, 0,  0, 0, 0, 0, 0, 0, 0, 1, 0,  0, 0, 0, 0, 0, 1, 1, 0, 0},  // R9
      '{9,  0, 0,  0, 0, 0, 0, 0, 0, 0, 1, 0,  0, 0, 0, 0, 0, 1, 0, 0, 0},  // R9
      '{4,  0, 3,  0, 1, 1, 0, 0, 0, 0, 0, 0,  0, 0, 1, 0, 0, 6, 0, 0, 0},  // R4 both device reqs
      '{7,  0, 0,  1, 0, 0, 0, 0, 0, 0, 0, 0,  0, 0, 0, 0, 1, 1, 1, 0, 0}   // R7
   };

   task automatic chk(input string what, input int rq, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL R%0d %s: got %0d expected %0d", rq, what, act, exp);
      end
   endtask

   // R5: mode bits derived from the expected status code
   function automatic int mb_of(input int sts);
      return (sts == 6) ? 2 : (sts == 2) ? 1 : 0;
   endfunction

   task automatic idle();
      sw_req = 0; ack_en = 0; wake_cmd = 0; irq_en = 0; clr_chg = 0; clr_wake = 0;
      rx_pmreq_p = 0; rx_pmreq_s = 0; rx_pmack = 0; rx_pmnak = 0; rx_oob_wake = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      idle();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #1;
      // R1 reset state
      chk("reset status", 1, ipm_status, 1);
      chk("reset mode_bits", 1, mode_bits, 0);
      chk("reset tx", 1, {tx_pmreq_p, tx_pmreq_s, tx_pmack, tx_pmnak, tx_comwake}, 0);
      chk("reset flags", 1, {mode_chg, wake_rx, irq}, 0);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         sw_req = VEC[i].sw; ack_en = {2'b00, VEC[i].ae}; wake_cmd = VEC[i].wk;
         rx_pmreq_p = VEC[i].rp; rx_pmreq_s = VEC[i].rs; rx_pmack = VEC[i].ra;
         rx_pmnak = VEC[i].rn; rx_oob_wake = VEC[i].ob; irq_en = VEC[i].ie;
         clr_chg = VEC[i].cc; clr_wake = VEC[i].cw;
         @(posedge clk); #1;
         chk($sformatf("v%0d tx_pmreq_p", i), VEC[i].rq, tx_pmreq_p, VEC[i].ep);
         chk($sformatf("v%0d tx_pmreq_s", i), VEC[i].rq, tx_pmreq_s, VEC[i].es);
         chk($sformatf("v%0d tx_pmack", i), VEC[i].rq, tx_pmack, VEC[i].ek);
         chk($sformatf("v%0d tx_pmnak", i), VEC[i].rq, tx_pmnak, VEC[i].en);
         chk($sformatf("v%0d tx_comwake", i), VEC[i].rq, tx_comwake, VEC[i].ec);
         chk($sformatf("v%0d ipm_status", i), VEC[i].rq, ipm_status, VEC[i].sts);
         chk($sformatf("v%0d mode_bits", i), 5, mode_bits, mb_of(VEC[i].sts));
         chk($sformatf("v%0d mode_chg", i), VEC[i].rq, mode_chg, VEC[i].echg);
         chk($sformatf("v%0d wake_rx", i), VEC[i].rq, wake_rx, VEC[i].ewk);
         chk($sformatf("v%0d irq", i), VEC[i].rq, irq, VEC[i].eirq);
      end

      // R3: repeated refusals keep the Partial request going
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); idle(); sw_req = 2'b01; rx_pmnak = 1;
         @(posedge clk); #1;
         chk("nak repeat tx_pmreq_p", 3, tx_pmreq_p, 1);
         chk("nak repeat status", 3, ipm_status, 1);
      end

      // R1: reset in the middle of Partial
      @(negedge clk); idle(); sw_req = 2'b01; rx_pmack = 1;
      @(posedge clk); #1;
      chk("enter before reset", 3, ipm_status, 2);
      @(negedge clk); idle(); rst_n = 1'b0;
      #1;
      chk("mid reset status", 1, ipm_status, 1);
      chk("mid reset flags", 1, {mode_chg, wake_rx, irq}, 0);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #1;
      chk("after reset status", 1, ipm_status, 1);

      // R10: enable with no pending change gives no interrupt
      @(negedge clk); idle(); irq_en = 1;
      @(posedge clk); #1;
      chk("irq without change", 10, irq, 0);

      @(negedge clk); idle();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule